// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer with a small word-addressed register port. An up-counter advances on pulses of a slow time base, optionally through a power-of-two prescaler. Once it passes its all-ones value it requests a system reset and starts again from a programmable reload value. Software cannot start or stop the counter with a single write. It must commit an ordered pair of key words to the key register. Software keeps the counter away from overflow by writing a trigger register with a value that differs from the one it already holds.

Every write to the four writable registers is posted. The word is captured at once and a per-register pending flag is raised. The word takes effect only on the second slow-time-base pulse after capture, and the flag drops at that point. This models the hand-over into the slow counting domain. The slow domain is represented by a single-cycle enable, `slow_tick`, that is synchronous to `clk`.

Register map (word addresses): 0 control, 1 reload value, 2 key, 3 trigger, 4 counter (read only), 5 pending flags (read only), 6 run state (read only). Reads are combinational and return committed values, zero-extended to the bus width.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, every register reads zero: control, reload, key, trigger, counter, pending flags and run state. Address 7 also reads zero.
- R2: Committing 0x0000BBBB to the key register and then committing 0x00004444 as the next key word sets the run state (address 6, bit 0) to 1.
- R3: Committing 0x0000AAAA and then 0x00005555 as the next key word clears the run state to 0.
- R4: If a first key word is followed by a key word that is not its partner, the pair is discarded and the run state keeps its value.
- R5: The pending register (address 5) has one bit per writable register: bit 0 control, bit 1 reload, bit 2 key, bit 3 trigger. A bit is set in the cycle after its write is accepted. It clears, and the value takes effect, on the second `slow_tick` pulse after acceptance. The pending register reads 0 when no write is outstanding.
- R6: A write to a register whose pending bit is set is dropped, and the held value is not altered.
- R7: A commit to the control or reload register has no effect while the run state is 1.
- R8: While running with the prescaler off, the counter increases by one on each `slow_tick`. While stopped, the counter holds its value.
- R9: Control bit 0 enables the prescaler and control bits [4:2] hold the exponent P. With the prescaler on, the counter advances once every 2^P running ticks. The prescaler phase restarts from zero whenever the watchdog is stopped.
- R10: A trigger commit whose value differs from the held trigger value loads the counter from the reload register. A commit of an equal value leaves the counter untouched.
- R11: On a running tick that advances an all-ones counter, the counter takes the reload value and `rst_req` is high for exactly that one clock cycle.
- R12: When a trigger reload and a count advance fall on the same tick, the reload wins and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse marking each slow time-base period |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| rst_req | output | 1 | One-cycle reset request on counter overflow |

## Verification
Key pairs are exercised in order, with a mismatched partner, and as stop pairs. This separates a correct two-step sequence from one that acts on single words or ignores order. Writes are issued back-to-back to the same register and spaced apart, which shows whether dropping behind a pending flag and the two-tick commit latency are implemented. Counting is run with the prescaler off and with a non-zero exponent, and with reload values near all-ones. This distinguishes tick rate, prescale phase, wrap value and the one-cycle reset pulse. Trigger writes with a changed value and with a repeated value confirm that only a change reloads the counter.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
   localparam int NUM_POST  = 4;
   localparam int SLOT_CTRL = 0;
   localparam int SLOT_LOAD = 1;
   localparam int SLOT_KEY  = 2;
   localparam int SLOT_TRIG = 3;
   localparam int RD_COUNT  = 4;
   localparam int RD_PEND   = 5;
   localparam int RD_RUN    = 6;

   localparam logic [31:0] KEY_START_A = 32'h0000_BBBB;
   localparam logic [31:0] KEY_START_B = 32'h0000_4444;
   localparam logic [31:0] KEY_STOP_A  = 32'h0000_AAAA;
   localparam logic [31:0] KEY_STOP_B  = 32'h0000_5555;

   typedef enum logic [1:0] {
      ARM_NONE  = 2'd0,
      ARM_START = 2'd1,
      ARM_STOP  = 2'd2
   } arm_e;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
   parameter int W   = 32,
   parameter int LAT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic         pend,
   output logic         commit,
   output logic [W-1:0] held
);
   localparam int AW = (LAT > 1) ? $clog2(LAT) : 1;

   if (LAT < 1) begin : g_bad_lat
      $error("wdt_post_slot: LAT must be at least 1");
   end

   logic accept;
   assign accept = wr && !pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
      end else if (accept) begin
         held <= wdata;
      end
   end

   if (LAT == 1) begin : g_direct
      assign commit = pend && tick;
      always_ff @(posedge clk) begin
         if (!rst_n)       pend <= 1'b0;
         else if (accept)  pend <= 1'b1;
         else if (commit)  pend <= 1'b0;
      end
   end else begin : g_aged
      logic [AW-1:0] age;
      assign commit = pend && tick && (age == AW'(LAT - 1));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend <= 1'b0;
            age  <= '0;
         end else if (accept) begin
            pend <= 1'b1;
            age  <= '0;
         end else if (commit) begin
            pend <= 1'b0;
         end else if (pend && tick) begin
            age <= age + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_keyed_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic [W-1:0] word,
   output logic         run
);
   if (W < 16) begin : g_bad_w
      $error("wdt_key_seq: key words need at least 16 bits");
   end

   arm_e arm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm <= ARM_NONE;
         run <= 1'b0;
      end else if (commit) begin
         if (word == W'(KEY_START_A)) begin
            arm <= ARM_START;
         end else if (word == W'(KEY_STOP_A)) begin
            arm <= ARM_STOP;
         end else if (arm == ARM_START && word == W'(KEY_START_B)) begin
            arm <= ARM_NONE;
            run <= 1'b1;
         end else if (arm == ARM_STOP && word == W'(KEY_STOP_B)) begin
            arm <= ARM_NONE;
            run <= 1'b0;
         end else begin
            arm <= ARM_NONE;
         end
      end
   end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
   parameter int CNT_W = 32,
   parameter int PTV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             pre_en,
   input  logic [PTV_W-1:0] ptv,
   input  logic [CNT_W-1:0] load,
   input  logic             reload,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam int PCNT_W = 1 << PTV_W;

   if (PTV_W < 1 || PTV_W > 5) begin : g_bad_ptv
      $error("wdt_tick_counter: PTV_W must be 1..5");
   end

   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] mask;
   logic              adv;

   assign mask = ~({PCNT_W{1'b1}} << ptv);
   assign adv  = !pre_en || ((pcnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         pcnt  <= '0;
         ovf   <= 1'b0;
      end else begin
         ovf <= 1'b0;
         if (!run) begin
            pcnt <= '0;
         end
         if (reload) begin
            count <= load;
         end else if (tick && run) begin
            pcnt <= pcnt + 1'b1;
            if (adv) begin
               if (&count) begin
                  count <= load;
                  ovf   <= 1'b1;
               end else begin
                  count <= count + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
   import wdt_keyed_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int CNT_W    = 32,
   parameter int PTV_W    = 3,
   parameter int PTV_LSB  = 2,
   parameter int POST_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_req
);
   localparam int CTRL_W = PTV_LSB + PTV_W;

   if (ADDR_W < 3)          begin : g_bad_addr $error("ADDR_W must be at least 3"); end
   if (CNT_W > DATA_W)      begin : g_bad_cnt  $error("CNT_W exceeds DATA_W"); end
   if (CTRL_W > DATA_W)     begin : g_bad_ctrl $error("control field exceeds DATA_W"); end
   if (PTV_LSB < 1)         begin : g_bad_lsb  $error("PTV_LSB must leave bit 0 free"); end

   logic [NUM_POST-1:0] pend;
   logic [NUM_POST-1:0] commit;
   logic [DATA_W-1:0]   held [NUM_POST];

   for (genvar g = 0; g < NUM_POST; g++) begin : g_slot
      wdt_post_slot #(
         .W   (DATA_W),
         .LAT (POST_LAT)
      ) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (slow_tick),
         .wr     (wr_en && (addr == ADDR_W'(g))),
         .wdata  (wdata),
         .pend   (pend[g]),
         .commit (commit[g]),
         .held   (held[g])
      );
   end

   logic              run;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  load_q;
   logic [DATA_W-1:0] key_q;
   logic [DATA_W-1:0] trig_q;
   logic              reload;
   logic [CNT_W-1:0]  count;

   assign reload = commit[SLOT_TRIG] && (held[SLOT_TRIG] != trig_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         key_q  <= '0;
         trig_q <= '0;
      end else begin
         if (commit[SLOT_CTRL] && !run) ctrl_q <= held[SLOT_CTRL][CTRL_W-1:0];
         if (commit[SLOT_LOAD] && !run) load_q <= held[SLOT_LOAD][CNT_W-1:0];
         if (commit[SLOT_KEY])          key_q  <= held[SLOT_KEY];
         if (commit[SLOT_TRIG])         trig_q <= held[SLOT_TRIG];
      end
   end

   wdt_key_seq #(
      .W (DATA_W)
   ) u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit[SLOT_KEY]),
      .word   (held[SLOT_KEY]),
      .run    (run)
   );

   wdt_tick_counter #(
      .CNT_W (CNT_W),
      .PTV_W (PTV_W)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (slow_tick),
      .run    (run),
      .pre_en (ctrl_q[0]),
      .ptv    (ctrl_q[PTV_LSB +: PTV_W]),
      .load   (load_q),
      .reload (reload),
      .count  (count),
      .ovf    (rst_req)
   );

   always_comb begin
      rdata = '0;
      case (int'(addr))
         SLOT_CTRL: rdata = DATA_W'(ctrl_q);
         SLOT_LOAD: rdata = DATA_W'(load_q);
         SLOT_KEY:  rdata = key_q;
         SLOT_TRIG: rdata = trig_q;
         RD_COUNT:  rdata = DATA_W'(count);
         RD_PEND:   rdata = DATA_W'(pend);
         RD_RUN:    rdata = DATA_W'(run);
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
   parameter int CNT_W  = 32,
   parameter int CTRL_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              run,
   input logic [3:0]        pend,
   input logic [3:0]        commit,
   input logic [CNT_W-1:0]  count,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [CNT_W-1:0]  load_q,
   input logic              rst_req
);
   p_pend_clears_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend) & ~pend)) |-> $past(tick));

   p_run_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run != $past(run)) |-> $past(commit[2]));

   p_ctrl_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> !$past(run));

   p_load_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_q != $past(load_q)) |-> !$past(run));

   p_hold_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run) && !$past(commit[3])) |-> $stable(count));

   p_ovf_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(tick) && $past(run) && !$past(commit[3])));

   p_ovf_wraps_to_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (count == load_q));
endmodule

bind wdt_keyed_top wdt_keyed_chk #(
   .CNT_W  (CNT_W),
   .CTRL_W (CTRL_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (slow_tick),
   .run     (run),
   .pend    (pend),
   .commit  (commit),
   .count   (count),
   .ctrl_q  (ctrl_q),
   .load_q  (load_q),
   .rst_req (rst_req)
);

// File: tb/wdt_keyed_top_bench.sv
module wdt_keyed_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int tick_div = 4;
   int cyc = 0;
   int ovf_seen = 0;

   always #10 clk = ~clk;

   wdt_keyed_top u_wdt_keyed_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .rst_req   (rst_req)
   );

   // behavioural reference
   logic [31:0] m_ctrl, m_load, m_key, m_trig, m_cnt;
   logic [31:0] m_hold [4];
   bit          m_pend [4];
   int          m_age  [4];
   bit          m_run, m_rst;
   int          m_arm, m_pcnt;

   function automatic logic [31:0] mread(input logic [2:0] a);
      case (a)
         3'd0: return m_ctrl & 32'h1F;
         3'd1: return m_load;
         3'd2: return m_key;
         3'd3: return m_trig;
         3'd4: return m_cnt;
         3'd5: return {28'd0, m_pend[3], m_pend[2], m_pend[1], m_pend[0]};
         3'd6: return {31'd0, m_run};
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_load = 0; m_key = 0; m_trig = 0; m_cnt = 0;
         m_run = 0; m_rst = 0; m_arm = 0; m_pcnt = 0;
         for (int i = 0; i < 4; i++) begin
            m_hold[i] = 0; m_pend[i] = 0; m_age[i] = 0;
         end
      end else begin
         bit          c [4];
         bit          run_o, reload, adv;
         logic [31:0] load_o;
         int          mask;
         run_o  = m_run;
         load_o = m_load;
         m_rst  = 0;
         for (int i = 0; i < 4; i++) begin
            c[i] = 0;
            if (m_pend[i] && slow_tick) begin
               if (m_age[i] == 1) begin c[i] = 1; m_pend[i] = 0; end
               else m_age[i] = m_age[i] + 1;
            end else if (!m_pend[i] && wr_en && addr == 3'(i)) begin
               m_pend[i] = 1; m_age[i] = 0; m_hold[i] = wdata;
            end
         end
         if (c[0] && !run_o) m_ctrl = m_hold[0] & 32'h1F;
         if (c[1] && !run_o) m_load = m_hold[1];
         if (c[2]) begin
            m_key = m_hold[2];
            if (m_key == 32'hBBBB) m_arm = 1;
            else if (m_key == 32'hAAAA) m_arm = 2;
            else if (m_arm == 1 && m_key == 32'h4444) begin m_run = 1; m_arm = 0; end
            else if (m_arm == 2 && m_key == 32'h5555) begin m_run = 0; m_arm = 0; end
            else m_arm = 0;
         end
         reload = 0;
         if (c[3]) begin
            reload = (m_hold[3] != m_trig);
            m_trig = m_hold[3];
         end
         if (!run_o) m_pcnt = 0;
         if (reload) begin
            m_cnt = load_o;
         end else if (slow_tick && run_o) begin
            mask = (1 << ((m_ctrl >> 2) & 7)) - 1;
            adv  = !m_ctrl[0] || ((m_pcnt & mask) == mask);
            m_pcnt = (m_pcnt + 1) % 256;
            if (adv) begin
               if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = load_o; m_rst = 1; end
               else m_cnt = m_cnt + 1;
            end
         end
      end
   end

   // slow time base and input timing: inputs change 2 ns after the rising edge
   always @(posedge clk) begin
      cyc++;
      #2;
      slow_tick = (tick_div == 1) ? 1'b1 : ((cyc % tick_div) == 0);
   end

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0, 3'd1: return "R7";
         3'd2: return "R2";
         3'd3: return "R10";
         3'd4: return "R8";
         3'd5: return "R5";
         3'd6: return "R3";
         default: return "R1";
      endcase
   endfunction

   // compare every cycle at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (rdata !== mread(addr)) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", tag_of(addr), addr, rdata, mread(addr));
         end
         checks++;
         if (rst_req !== m_rst) begin
            errors++;
            $display("FAIL R11 rst_req actual %0b expected %0b", rst_req, m_rst);
         end
         if (rst_req) ovf_seen++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic wr_settle(input logic [2:0] a, input logic [31:0] d);
      wr(a, d);
      idle(4 * tick_div + 4);
   endtask

   task automatic expect_v(input string tag, input logic [2:0] a, input logic [31:0] v);
      addr = a;
      @(negedge clk);
      checks++;
      if (rdata !== v) begin
         errors++;
         $display("FAIL %s addr %0d actual %h expected %h", tag, a, rdata, v);
      end
      @(posedge clk); #2;
   endtask

   task automatic expect_m(input string tag, input logic [2:0] a);
      addr = a;
      @(negedge clk);
      checks++;
      if (rdata !== mread(a)) begin
         errors++;
         $display("FAIL %s addr %0d actual %h expected %h", tag, a, rdata, mread(a));
      end
      @(posedge clk); #2;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual running expected finished");
         summary();
      end
   end

   initial begin
      logic [31:0] snap;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: everything zero after reset
      for (int a = 0; a < 8; a++) expect_v("R1", 3'(a), 32'd0);

      // R5: pending bit set after write, cleared after two ticks
      wr(3'd0, 32'h0);
      expect_v("R5", 3'd5, 32'h1);
      idle(4 * tick_div + 4);
      expect_v("R5", 3'd5, 32'h0);

      // R6: second back-to-back write to reload is dropped
      wr(3'd1, 32'h100);
      wr(3'd1, 32'h200);
      idle(4 * tick_div + 4);
      expect_v("R6", 3'd1, 32'h100);

      // R4: start key with wrong partner leaves run state alone
      wr_settle(3'd2, 32'hBBBB);
      wr_settle(3'd2, 32'h5555);
      expect_v("R4", 3'd6, 32'h0);
      wr_settle(3'd2, 32'h4444);
      expect_v("R4", 3'd6, 32'h0);

      // R2: proper start sequence
      wr_settle(3'd2, 32'hBBBB);
      wr_settle(3'd2, 32'h4444);
      expect_v("R2", 3'd6, 32'h1);
      idle(20);
      expect_m("R8", 3'd4);

      // R7: configuration commits ignored while running
      wr_settle(3'd1, 32'h300);
      expect_v("R7", 3'd1, 32'h100);
      wr_settle(3'd0, 32'h1D);
      expect_v("R7", 3'd0, 32'h0);

      // R10 and R12: changed trigger reloads (on a running tick), equal one does not
      wr_settle(3'd3, 32'h1);
      expect_m("R12", 3'd4);
      expect_v("R10", 3'd3, 32'h1);
      wr_settle(3'd3, 32'h1);
      expect_m("R10", 3'd4);

      // R3: stop sequence, then counter holds
      wr_settle(3'd2, 32'hAAAA);
      wr_settle(3'd2, 32'h5555);
      expect_v("R3", 3'd6, 32'h0);
      addr = 3'd4;
      @(negedge clk) snap = rdata;
      idle(30);
      expect_v("R8", 3'd4, snap);

      // R9: prescaler on, exponent 2
      wr_settle(3'd0, 32'h1 | (32'd2 << 2));
      expect_v("R9", 3'd0, 32'h9);
      wr_settle(3'd2, 32'hBBBB);
      wr_settle(3'd2, 32'h4444);
      idle(60);
      expect_m("R9", 3'd4);
      wr_settle(3'd2, 32'hAAAA);
      wr_settle(3'd2, 32'h5555);

      // R11: overflow near all-ones with fast ticks
      tick_div = 2;
      wr_settle(3'd0, 32'h0);
      wr_settle(3'd1, 32'hFFFF_FFF0);
      wr_settle(3'd2, 32'hBBBB);
      wr_settle(3'd2, 32'h4444);
      wr_settle(3'd3, 32'h2);
      idle(60);
      checks++;
      if (ovf_seen < 1) begin
         errors++;
         $display("FAIL R11 reset pulses actual %0d expected >=1", ovf_seen);
      end
      expect_m("R11", 3'd4);

      done = 1;
      summary();
   end
endmodule